// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of general-purpose I/O for a chip: it owns 32 pads and gives each one a control word in a small register space. Through that word software chooses whether the pad is driven and at what level, enables a pull resistor and picks its direction, and reads back the pad value after it has been synchronised to the bank clock. The pad drive and pull controls are plain outputs that go to the pad ring.

Each pin also has a detector that watches its synchronised input. The detector can look for a rising edge, a falling edge, either edge, a high level or a low level. A detected event on a pin whose interrupt is enabled sets a sticky pending bit. A bank-wide status register shows all 32 pending bits side by side. One registered interrupt line goes high while any enabled pin has a pending event. Software clears a pending bit by writing its control word with the pending bit set to one.

The register port is a single-cycle synchronous bus. A write takes effect at the clock edge where the write strobe is high. Read data is registered and appears one cycle after the read strobe.

Top module: `gpb_bank`

## Requirements
- R1: Pin n's control word sits at address n (0 to 31). Its bits are: 0 drive enable, 1 drive value, 2 synchronised input (read-only), 3 pull enable, 4 pull-up select, 5 interrupt enable, 6 pending (read, write-one-to-clear), 7 high-sense, 8 low-sense, 9 edge-type. Bits 10 to 31 read as zero.
- R2: After a synchronous active-low reset, every control word, the status register, every pad output and the interrupt line are zero.
- R3: pad_oe[n] equals bit 0 of word n. pad_out[n] equals bit 1 when bit 0 is set and is zero otherwise.
- R4: When bit 3 is set, bit 4 high drives pad_pull_up[n] and bit 4 low drives pad_pull_dn[n]. With bit 3 clear both are zero, and the two are never high together.
- R5: pad_in passes through two flops before it reaches bit 2. A change on a pad is visible on a read two clock edges after the pad is sampled.
- R6: Detection modes. Edge-type set: high-sense catches a rise and low-sense catches a fall, so both set catches either edge. Edge-type clear: high-sense fires while the input is 1 and low-sense fires while it is 0. With neither sense bit set the pin never fires.
- R7: A detected event sets the pin's pending bit only while that pin's interrupt enable is set. A pending bit stays set until it is cleared.
- R8: A write of word n with bit 6 set clears pin n's pending bit. A write with bit 6 clear leaves it unchanged. An event detected in the same cycle as the clear leaves the bit set, so a level that is still active re-asserts at once.
- R9: A write that sets bit 0 stores bit 5 as zero, whatever value was written to bit 5.
- R10: Address 32 reads the status register, whose bit n is pin n's pending bit. Writes to it have no effect.
- R11: irq is a register of the OR over all pins of (pending AND interrupt enable). For a rising edge on an enabled pin that is sampled at clock edge E0, irq is first high after edge E3.
- R12: rd_data is loaded at the clock edge where rd_en is high. Addresses 33 to 63 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Register address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad input values |
| pad_oe | output | 32 | Pad drive enables |
| pad_out | output | 32 | Pad drive values |
| pad_pull_up | output | 32 | Pull-up enables |
| pad_pull_dn | output | 32 | Pull-down enables |
| irq | output | 1 | Bank interrupt |

## Verification
The bench checks the exact edge on which irq rises after a pad edge. A missing or extra synchroniser stage, or a combinational interrupt, would move that edge by one cycle. It clears a level-sensitive pin whose level is still active and expects the pending bit to stay set; a design that let the clear win over the new event would read back zero. It writes bit 6 as zero, and also writes to the status address, and expects no change in either case. It writes a word with both drive enable and interrupt enable set and expects interrupt enable to read back as zero. Random rounds load random modes and then flip a random set of pads. A design that ignored the enable, swapped high-sense and low-sense, or treated a level mode as an edge mode would then give the wrong status vector.

// File: rtl/gpb_pkg.sv
// Shared definitions for the GPIO bank: bus width and control word layout.
// Assumes one bank of at most DATA_W pins so the status vector fits a word.
package gpb_pkg;

    localparam int DATA_W = 32;

    // Control word bit positions; software and the bench depend on these.
    localparam int B_OE   = 0;
    localparam int B_DOUT = 1;
    localparam int B_DIN  = 2;
    localparam int B_PEN  = 3;
    localparam int B_PUP  = 4;
    localparam int B_IEN  = 5;
    localparam int B_PEND = 6;
    localparam int B_HI   = 7;
    localparam int B_LO   = 8;
    localparam int B_EDGE = 9;

    // Stored per-pin configuration (writable fields only).
    typedef struct packed {
        logic edge_t;
        logic sense_lo;
        logic sense_hi;
        logic irq_en;
        logic pull_up;
        logic pull_en;
        logic drv_val;
        logic drv_en;
    } pin_cfg_t;

endpackage

// File: rtl/gpb_sync.sv
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherency is implied.
module gpb_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Two sampling stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;

endmodule

// File: rtl/gpb_pin_cell.sv
// One pin: configuration register, event detector and sticky pending bit.
// Assumes din is already synchronised to clk.
module gpb_pin_cell
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              din,
    output logic              drv_en,
    output logic              drv_out,
    output logic              pull_up,
    output logic              pull_dn,
    output logic              irq_en,
    output logic              pending,
    output logic [DATA_W-1:0] word
);

    pin_cfg_t cfg;
    logic     din_prev;
    logic     rise;
    logic     fall;
    logic     hit;
    logic     clr;

    // Configuration update; a driven pin never keeps its interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_sel) begin
            cfg.drv_en   <= wdata[B_OE];
            cfg.drv_val  <= wdata[B_DOUT];
            cfg.pull_en  <= wdata[B_PEN];
            cfg.pull_up  <= wdata[B_PUP];
            cfg.irq_en   <= wdata[B_IEN] & ~wdata[B_OE];
            cfg.sense_hi <= wdata[B_HI];
            cfg.sense_lo <= wdata[B_LO];
            cfg.edge_t   <= wdata[B_EDGE];
        end
    end

    // Previous synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) din_prev <= 1'b0;
        else        din_prev <= din;
    end

    // Event detection by mode bits.
    always_comb begin
        rise = din & ~din_prev;
        fall = ~din & din_prev;
        if (cfg.edge_t) hit = (cfg.sense_hi & rise) | (cfg.sense_lo & fall);
        else            hit = (cfg.sense_hi & din)  | (cfg.sense_lo & ~din);
    end

    assign clr = wr_sel & wdata[B_PEND];

    // Sticky pending bit: a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~clr) | (hit & cfg.irq_en);
    end

    // Pad controls and readback word.
    always_comb begin
        drv_en  = cfg.drv_en;
        drv_out = cfg.drv_val & cfg.drv_en;
        pull_up = cfg.pull_en & cfg.pull_up;
        pull_dn = cfg.pull_en & ~cfg.pull_up;
        irq_en  = cfg.irq_en;
        word            = '0;
        word[B_OE]      = cfg.drv_en;
        word[B_DOUT]    = cfg.drv_val;
        word[B_DIN]     = din;
        word[B_PEN]     = cfg.pull_en;
        word[B_PUP]     = cfg.pull_up;
        word[B_IEN]     = cfg.irq_en;
        word[B_PEND]    = pending;
        word[B_HI]      = cfg.sense_hi;
        word[B_LO]      = cfg.sense_lo;
        word[B_EDGE]    = cfg.edge_t;
    end

endmodule

// File: rtl/gpb_rdmux.sv
// Registered read-data selector over pin words and the status vector.
// Assumes NUM_PINS <= DATA_W; unmapped addresses return zero.
module gpb_rdmux
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_PINS-1:0][DATA_W-1:0] words,
    input  logic [NUM_PINS-1:0]            status,
    output logic [DATA_W-1:0]              rd_data
);

    logic [DATA_W-1:0] sel;

    // Address decode to the selected word.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (addr == ADDR_W'(i)) sel = words[i];
        end
        if (addr == ADDR_W'(NUM_PINS)) sel = DATA_W'(status);
    end

    // Capture on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

endmodule

// File: rtl/gpb_bank.sv
// GPIO bank top: synchroniser, one cell per pin, read mux, bank interrupt.
// Assumes a single clock domain for the bus and pad-control outputs.
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = $clog2(NUM_PINS) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_pull_up,
    output logic [NUM_PINS-1:0] pad_pull_dn,
    output logic                irq
);

    logic [NUM_PINS-1:0]             din_sync;
    logic [NUM_PINS-1:0]             status_vec;
    logic [NUM_PINS-1:0]             irq_en_vec;
    logic [NUM_PINS-1:0][DATA_W-1:0] word_arr;

    gpb_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        logic sel_w;
        assign sel_w = wr_en && (addr == ADDR_W'(gi));
        gpb_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (sel_w),
            .wdata   (wdata),
            .din     (din_sync[gi]),
            .drv_en  (pad_oe[gi]),
            .drv_out (pad_out[gi]),
            .pull_up (pad_pull_up[gi]),
            .pull_dn (pad_pull_dn[gi]),
            .irq_en  (irq_en_vec[gi]),
            .pending (status_vec[gi]),
            .word    (word_arr[gi])
        );
    end

    gpb_rdmux #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .words   (word_arr),
        .status  (status_vec),
        .rd_data (rd_data)
    );

    // Registered bank interrupt from enabled pending pins.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status_vec & irq_en_vec);
    end

endmodule

// File: rtl/gpb_bank_chk.sv
// Property checker for the GPIO bank, attached by bind.
// Assumes visibility of the top-level pending and enable vectors.
module gpb_bank_chk #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_pull_up,
    input logic [NUM_PINS-1:0] pad_pull_dn,
    input logic [NUM_PINS-1:0] status_vec,
    input logic [NUM_PINS-1:0] irq_en_vec,
    input logic                irq
);

    // R9
    driven_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & irq_en_vec) == '0);

    // R4
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_up & pad_pull_dn) == '0);

    // R3
    out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R7
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    // R11
    irq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status_vec & irq_en_vec))));

    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > ADDR_W'(NUM_PINS)) |=> (rd_data == '0));

endmodule

bind gpb_bank gpb_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (gpb_pkg::DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .rd_data     (rd_data),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_up (pad_pull_up),
    .pad_pull_dn (pad_pull_dn),
    .status_vec  (status_vec),
    .irq_en_vec  (irq_en_vec),
    .irq         (irq)
);

// File: tb/sim_gpb_bank.sv
module sim_gpb_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out, pad_pull_up, pad_pull_dn;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;  // 250 MHz

    gpb_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
        .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    // Expected pending bit after a config has seen pad value o then n (R6, R7).
    function automatic logic exp_pend(logic [31:0] w, logic o, logic n);
        logic en;
        en = w[5] & ~w[0];
        if (!en) return 1'b0;
        if (w[9]) return (w[7] & ~o & n) | (w[8] & o & ~n);
        return (w[7] & (o | n)) | (w[8] & (~o | ~n));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] cfgw [32];
        logic [31:0] oldp, newp, expst, expen;
        void'($urandom(32'd7741));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk("R2 pad_oe", pad_oe, 32'h0);
        chk("R2 pulls", pad_pull_up | pad_pull_dn | pad_out, 32'h0);
        chk("R2 irq", {31'h0, irq}, 32'h0);
        bus_rd(6'd32, rd); chk("R2 status", rd, 32'h0);
        bus_rd(6'd7, rd);  chk("R2 word7", rd, 32'h0);

        // R5 synchronised input readback
        @(negedge clk); pad_in[5] = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(6'd5, rd); chk("R5 din bit", rd, 32'h4);

        // R9 drive enable forces interrupt enable low
        bus_wr(6'd3, 32'h0000_0023);
        bus_rd(6'd3, rd); chk("R9 ien cleared", rd, 32'h3);
        chk("R3 pad_oe/out pin3", {pad_oe[3], pad_out[3]}, 32'h3);

        // R11 exact latency, rising edge on pin 0
        bus_wr(6'd0, 32'h0000_02A0);
        repeat (3) @(negedge clk);
        @(negedge clk); pad_in[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R11 irq not yet after E2", {31'h0, irq}, 32'h0);
        @(posedge clk);
        @(negedge clk); chk("R11 irq after E3", {31'h0, irq}, 32'h1);
        bus_rd(6'd32, rd); chk("R6 rise status", rd, 32'h1);

        // R10 status register is read-only
        bus_wr(6'd32, 32'h0);
        bus_rd(6'd32, rd); chk("R10 write zero ignored", rd, 32'h1);
        bus_wr(6'd32, 32'hFFFF_FFFF);
        bus_rd(6'd32, rd); chk("R10 write ones ignored", rd, 32'h1);

        // R8 clear only with bit 6 set
        bus_wr(6'd0, 32'h0000_02A0);
        bus_rd(6'd32, rd); chk("R8 no clear", rd, 32'h1);
        bus_wr(6'd0, 32'h0000_02E0);
        bus_rd(6'd32, rd); chk("R8 cleared", rd, 32'h0);
        chk("R11 irq dropped", {31'h0, irq}, 32'h0);

        // R8 level re-asserts through a clear
        bus_wr(6'd1, 32'h0000_00A0);
        @(negedge clk); pad_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd(6'd32, rd); chk("R6 level high", rd, 32'h2);
        bus_wr(6'd1, 32'h0000_00E0);
        bus_rd(6'd32, rd); chk("R8 level stays", rd, 32'h2);

        // R6 both edges on pin 2
        bus_wr(6'd2, 32'h0000_03A0);
        @(negedge clk); pad_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd(6'd32, rd); chk("R6 both rise", rd, 32'h6);
        bus_wr(6'd2, 32'h0000_03E0);
        bus_rd(6'd32, rd); chk("R8 both cleared", rd, 32'h2);
        @(negedge clk); pad_in[2] = 1'b0;
        repeat (4) @(negedge clk);
        bus_rd(6'd32, rd); chk("R6 both fall", rd, 32'h6);

        // R12 unmapped read
        bus_rd(6'd40, rd); chk("R12 unmapped zero", rd, 32'h0);

        // Random rounds (R1, R3, R4, R6, R7, R11)
        for (int r = 0; r < 8; r++) begin
            oldp = $urandom;
            @(negedge clk); pad_in = oldp;
            for (int i = 0; i < 32; i++) begin
                cfgw[i] = $urandom & 32'h0000_03BB;
                if ($urandom % 4 != 0) cfgw[i][0] = 1'b0;
                if ($urandom % 4 != 0) cfgw[i][5] = 1'b1;
            end
            for (int p = 0; p < 2; p++)
                for (int i = 0; i < 32; i++)
                    bus_wr(6'(i), cfgw[i] | 32'h40);
            newp = oldp ^ ($urandom & $urandom);
            @(negedge clk); pad_in = newp;
            repeat (6) @(negedge clk);
            expst = '0; expen = '0;
            for (int i = 0; i < 32; i++) begin
                expst[i] = exp_pend(cfgw[i], oldp[i], newp[i]);
                expen[i] = cfgw[i][5] & ~cfgw[i][0];
            end
            bus_rd(6'd32, rd); chk("R7 status vector", rd, expst);
            chk("R11 irq level", {31'h0, irq}, {31'h0, |(expst & expen)});
            begin
                logic [31:0] eoe, eout, epu, epd;
                for (int i = 0; i < 32; i++) begin
                    eoe[i]  = cfgw[i][0];
                    eout[i] = cfgw[i][0] & cfgw[i][1];
                    epu[i]  = cfgw[i][3] & cfgw[i][4];
                    epd[i]  = cfgw[i][3] & ~cfgw[i][4];
                end
                chk("R3 pad_oe", pad_oe, eoe);
                chk("R3 pad_out", pad_out, eout);
                chk("R4 pull_up", pad_pull_up, epu);
                chk("R4 pull_dn", pad_pull_dn, epd);
            end
            for (int i = 0; i < 32; i++) begin
                logic [31:0] ew;
                ew = cfgw[i];
                ew[5] = cfgw[i][5] & ~cfgw[i][0];
                ew[2] = newp[i];
                ew[6] = expst[i];
                bus_rd(6'(i), rd); chk("R1 word readback", rd, ew);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule